// File: doc/BRIEF.md
# Flash Status Polling Bit Generator

This block builds the word a flash device hands back when the host reads it while an embedded program or erase is in progress. The host polls this word to find out whether the operation is still running. Three bits carry the status. The data-polling bit reports the complement of the bit being written, or a fixed level. The main toggle bit changes on every completed read while an operation is busy. The sector toggle bit changes only for reads aimed at the sector that is being erased or is erase-suspended.

The operating mode, a sector-hit flag and the bit being written all come from outside, from a command decoder and sequencer that are not part of this block. A read strobe marks each host read, and a read is counted as complete when the strobe falls. In plain read mode, and for suspend-mode reads outside the suspended sector, the block passes the array data through unchanged.

Top module: `flash_status_poll`

## Requirements
- R1: After reset both toggle flip-flops are 0, so the first status read in a toggling mode shows 0 on each live toggle bit.
- R2: `mode` = 0 (read) or any code from 5 to 7 drives `rd_data` equal to `array_data`, and reads in these modes leave both toggle states unchanged.
- R3: `mode` = 1 (program) returns `!prog_bit` on bit 7. Bit 6 carries the main toggle state and flips after each completed read. Bit 2 reads 1.
- R4: `mode` = 2 (erase) returns 0 on bit 7. Bit 6 carries the main toggle state and flips after each completed read. Bit 2 carries the sector toggle state and flips after each completed read when `sector_hit` = 1. When `sector_hit` = 0, bit 2 reads 1 and the sector toggle state holds.
- R5: `mode` = 3 (erase-suspend read) with `sector_hit` = 1 returns 1 on bits 7 and 6. Bit 2 carries the sector toggle state and flips after each completed read. The main toggle state holds.
- R6: `mode` = 3 with `sector_hit` = 0 passes `array_data` through, and neither toggle state changes.
- R7: `mode` = 4 (erase-suspend program) returns `!prog_bit` on bit 7. Bit 6 carries the main toggle state and flips after each completed read. Bit 2 reads 1.
- R8: A toggle state changes at most once per read, on the clock edge that sees `rd_strobe` fall. Idle clocks and a strobe held high for several cycles cause no further change.
- R9: A change of mode clears neither toggle state. The next read in any toggling mode continues from the held value.
- R10: In modes 1, 2, 4, and in mode 3 with `sector_hit` = 1, every bit of `rd_data` other than bits 7, 6 and 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode code: 0 read, 1 program, 2 erase, 3 erase-suspend read, 4 erase-suspend program |
| sector_hit | input | 1 | Read address falls in the sector being erased or suspended |
| prog_bit | input | 1 | Data bit being programmed at the polled location |
| rd_strobe | input | 1 | High while a host read is in progress; the read completes when it falls |
| array_data | input | 16 | Word read from the array |
| rd_data | output | 16 | Word returned to the host |

## Verification
The bench goes after the counting of reads. A strobe held high for several cycles must flip a toggle only once. A design that toggled on level instead of on the falling edge would advance by several states. The bench also interleaves modes without resetting, so a design that cleared toggle state on a mode change would show a repeated value where an alternation is due. Suspend reads both inside and outside the suspended sector check that neither toggle moves when it should not. A design that flipped the main toggle in suspend-read, or the sector toggle on an erase read outside the sector, would lose step with the bench's model on the following read.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_SREAD = 3'd3,
    M_SPROG = 3'd4
  } fsp_mode_e;

  typedef enum logic [1:0] {
    SRC_LIVE = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_ZERO = 2'd2,
    SRC_INV  = 2'd3
  } bit_src_e;

  typedef struct packed {
    logic     show_status;
    bit_src_e poll_src;
    bit_src_e tog_src;
    bit_src_e stog_src;
    logic     tog_en;
    logic     stog_en;
  } fsp_ctrl_t;

  function automatic fsp_ctrl_t decode_mode(input logic [2:0] m, input logic hit);
    fsp_ctrl_t c;
    c.show_status = 1'b0;
    c.poll_src    = SRC_ZERO;
    c.tog_src     = SRC_ZERO;
    c.stog_src    = SRC_ZERO;
    c.tog_en      = 1'b0;
    c.stog_en     = 1'b0;
    case (m)
      M_PROG, M_SPROG: begin
        c.show_status = 1'b1;
        c.poll_src    = SRC_INV;
        c.tog_src     = SRC_LIVE;
        c.stog_src    = SRC_ONE;
        c.tog_en      = 1'b1;
      end
      M_ERASE: begin
        c.show_status = 1'b1;
        c.poll_src    = SRC_ZERO;
        c.tog_src     = SRC_LIVE;
        c.stog_src    = hit ? SRC_LIVE : SRC_ONE;
        c.tog_en      = 1'b1;
        c.stog_en     = hit;
      end
      M_SREAD: begin
        if (hit) begin
          c.show_status = 1'b1;
          c.poll_src    = SRC_ONE;
          c.tog_src     = SRC_ONE;
          c.stog_src    = SRC_LIVE;
          c.stog_en     = 1'b1;
        end
      end
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic pick_bit(input bit_src_e s, input logic live, input logic src_bit);
    case (s)
      SRC_LIVE: return live;
      SRC_ONE:  return 1'b1;
      SRC_INV:  return ~src_bit;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fsp_mode_decode.sv
module fsp_mode_decode
  import fsp_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       sector_hit,
  output fsp_ctrl_t  ctrl
);
  always_comb begin
    ctrl = decode_mode(mode, sector_hit);
  end
endmodule

// File: rtl/fsp_read_edge.sv
module fsp_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  output logic rd_done
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= rd_strobe;
  end

  assign rd_done = strobe_q & ~rd_strobe;
endmodule

// File: rtl/fsp_toggle_bank.sv
module fsp_toggle_bank #(
  parameter int unsigned NUM_TOG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_done,
  input  logic [NUM_TOG-1:0] flip_en,
  output logic [NUM_TOG-1:0] tog_q
);
  for (genvar g = 0; g < NUM_TOG; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      tog_q[g] <= 1'b0;
      else if (rd_done && flip_en[g])  tog_q[g] <= ~tog_q[g];
    end
  end
endmodule

// File: rtl/fsp_word_mux.sv
module fsp_word_mux
  import fsp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_POS = 7,
  parameter int unsigned TOG_POS  = 6,
  parameter int unsigned STOG_POS = 2
) (
  input  fsp_ctrl_t          ctrl,
  input  logic               prog_bit,
  input  logic               tog_live,
  input  logic               stog_live,
  input  logic [DATA_W-1:0]  array_data,
  output logic [DATA_W-1:0]  rd_data
);
  always_comb begin
    if (!ctrl.show_status) begin
      rd_data = array_data;
    end else begin
      rd_data           = '0;
      rd_data[POLL_POS] = pick_bit(ctrl.poll_src, 1'b0, prog_bit);
      rd_data[TOG_POS]  = pick_bit(ctrl.tog_src, tog_live, prog_bit);
      rd_data[STOG_POS] = pick_bit(ctrl.stog_src, stog_live, prog_bit);
    end
  end
endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll
  import fsp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_POS = 7,
  parameter int unsigned TOG_POS  = 6,
  parameter int unsigned STOG_POS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              sector_hit,
  input  logic              prog_bit,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned NUM_TOG  = 2;
  localparam int unsigned IDX_MAIN = 0;
  localparam int unsigned IDX_SECT = 1;

  fsp_ctrl_t          ctrl;
  logic               rd_done;
  logic [NUM_TOG-1:0] flip_en;
  logic [NUM_TOG-1:0] tog_vec;
  logic               tog_q;
  logic               stog_q;
  logic               tog_en;
  logic               stog_en;

  fsp_mode_decode u_dec (
    .mode       (mode),
    .sector_hit (sector_hit),
    .ctrl       (ctrl)
  );

  fsp_read_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .rd_done   (rd_done)
  );

  assign tog_en            = ctrl.tog_en;
  assign stog_en           = ctrl.stog_en;
  assign flip_en[IDX_MAIN] = tog_en;
  assign flip_en[IDX_SECT] = stog_en;

  fsp_toggle_bank #(.NUM_TOG(NUM_TOG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_done (rd_done),
    .flip_en (flip_en),
    .tog_q   (tog_vec)
  );

  assign tog_q  = tog_vec[IDX_MAIN];
  assign stog_q = tog_vec[IDX_SECT];

  fsp_word_mux #(
    .DATA_W   (DATA_W),
    .POLL_POS (POLL_POS),
    .TOG_POS  (TOG_POS),
    .STOG_POS (STOG_POS)
  ) u_mux (
    .ctrl       (ctrl),
    .prog_bit   (prog_bit),
    .tog_live   (tog_q),
    .stog_live  (stog_q),
    .array_data (array_data),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_POS = 7,
  parameter int unsigned TOG_POS  = 6,
  parameter int unsigned STOG_POS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              sector_hit,
  input logic              prog_bit,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_done,
  input logic              tog_en,
  input logic              stog_en,
  input logic              tog_q,
  input logic              stog_q
);
  // R8
  main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(tog_q));

  // R8
  sect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(stog_q));

  // R3
  main_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && tog_en) |=> (tog_q != $past(tog_q)));

  // R4
  sect_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && stog_en) |=> (stog_q != $past(stog_q)));

  // R2
  read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> (rd_data == array_data));

  // R3
  prog_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (rd_data[POLL_POS] != prog_bit && rd_data[STOG_POS]));

  // R4
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> !rd_data[POLL_POS]);

  // R5
  sread_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && sector_hit) |-> (rd_data[POLL_POS] && rd_data[TOG_POS] && !tog_en));

  // R6
  sread_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !sector_hit) |-> (rd_data == array_data && !stog_en));

  // R7
  sprog_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (rd_data[POLL_POS] != prog_bit && rd_data[STOG_POS]));
endmodule

bind flash_status_poll fsp_checker #(
  .DATA_W   (DATA_W),
  .POLL_POS (POLL_POS),
  .TOG_POS  (TOG_POS),
  .STOG_POS (STOG_POS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .sector_hit (sector_hit),
  .prog_bit   (prog_bit),
  .array_data (array_data),
  .rd_data    (rd_data),
  .rd_done    (rd_done),
  .tog_en     (tog_en),
  .stog_en    (stog_en),
  .tog_q      (tog_q),
  .stog_q     (stog_q)
);

// File: tb/flash_status_poll_tb.sv
`timescale 1ns/1ps
module flash_status_poll_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic          sector_hit = 1'b0;
  logic          prog_bit = 1'b0;
  logic          rd_strobe = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit m_tog = 0;
  bit m_stog = 0;

  always #2 clk = ~clk;

  flash_status_poll u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .sector_hit (sector_hit),
    .prog_bit   (prog_bit),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .rd_data    (rd_data)
  );

  function automatic logic [DW-1:0] expect_word(input logic [2:0] m, input bit hit,
      input bit pb, input logic [DW-1:0] ad, input bit t, input bit s);
    logic [DW-1:0] w;
    w = '0;
    case (m)
      3'd1, 3'd4: begin w[7] = ~pb; w[6] = t; w[2] = 1'b1; end
      3'd2:       begin w[7] = 1'b0; w[6] = t; w[2] = hit ? s : 1'b1; end
      3'd3:       if (hit) begin w[7] = 1'b1; w[6] = 1'b1; w[2] = s; end
                  else w = ad;
      default:    w = ad;
    endcase
    return w;
  endfunction

  function automatic string req_of(input logic [2:0] m, input bit hit);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return hit ? "R5" : "R6";
      3'd4: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] m, input bit hit, input bit pb,
      input logic [DW-1:0] ad, input int hold, input string tag);
    @(negedge clk);
    mode = m; sector_hit = hit; prog_bit = pb; array_data = ad; rd_strobe = 1'b1;
    @(negedge clk);
    check(rd_data, expect_word(m, hit, pb, ad, m_tog, m_stog),
          (tag != "") ? tag : req_of(m, hit));
    for (int i = 0; i < hold; i++) @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
    if (m == 3'd1 || m == 3'd2 || m == 3'd4) m_tog = ~m_tog;
    if (hit && (m == 3'd2 || m == 3'd3)) m_stog = ~m_stog;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] snap;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: first erase read on a hit shows 0 on both live toggles
    do_read(3'd2, 1'b1, 1'b0, 16'hffff, 0, "R1");
    do_read(3'd2, 1'b1, 1'b0, 16'hffff, 0, "R4");
    // R2: read mode passes data and holds toggles
    do_read(3'd0, 1'b0, 1'b0, 16'ha5c3, 0, "R2");
    do_read(3'd6, 1'b1, 1'b1, 16'h3c5a, 0, "R2");
    do_read(3'd2, 1'b1, 1'b0, 16'h0000, 0, "R2");
    // R3 program, both prog_bit values
    do_read(3'd1, 1'b0, 1'b1, 16'h1234, 0, "R3");
    do_read(3'd1, 1'b1, 1'b0, 16'h1234, 0, "R3");
    // R4: erase read off-sector, sector toggle holds
    do_read(3'd2, 1'b0, 1'b0, 16'h0000, 0, "R4");
    do_read(3'd2, 1'b1, 1'b0, 16'h0000, 0, "R4");
    // R5 / R6 suspend reads
    do_read(3'd3, 1'b1, 1'b0, 16'h7777, 0, "R5");
    do_read(3'd3, 1'b0, 1'b0, 16'hbeef, 0, "R6");
    do_read(3'd3, 1'b1, 1'b0, 16'h7777, 0, "R5");
    // R7 suspend program
    do_read(3'd4, 1'b0, 1'b0, 16'h0f0f, 0, "R7");
    do_read(3'd4, 1'b1, 1'b1, 16'h0f0f, 0, "R7");
    // R8: long strobe counts once
    do_read(3'd2, 1'b1, 1'b0, 16'h0, 5, "R8");
    do_read(3'd2, 1'b1, 1'b0, 16'h0, 0, "R8");
    // R8: idle clocks in erase leave output unchanged
    @(negedge clk);
    mode = 3'd2; sector_hit = 1'b1;
    @(negedge clk);
    snap = rd_data;
    repeat (6) @(negedge clk);
    check(rd_data, snap, "R8");
    check(rd_data, expect_word(3'd2, 1'b1, 1'b0, 16'h0, m_tog, m_stog), "R8");
    // R9: mode hop without clearing
    do_read(3'd1, 1'b0, 1'b0, 16'h0, 0, "R9");
    do_read(3'd3, 1'b1, 1'b0, 16'h0, 0, "R9");
    do_read(3'd2, 1'b1, 1'b0, 16'h0, 0, "R9");
    // R10: other bits zero with busy array data
    do_read(3'd1, 1'b0, 1'b0, 16'hffff, 0, "R10");
    do_read(3'd3, 1'b1, 1'b0, 16'hffff, 0, "R10");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] rm;
      rm = 3'($urandom_range(0, 7));
      do_read(rm, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
              DW'($urandom), $urandom_range(0, 3), "");
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule